// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Show-Ahead and Output Stage

A synchronous first-in first-out buffer running on one clock. A producer pushes words with a write request and a consumer pops them with a read request. The block reports a full flag, an empty flag and a count of stored words. A synchronous clear input discards all stored contents.

Two compile-time switches fix the read behaviour. `SHOW_AHEAD` selects one of two read styles. When it is 0, a word appears on `rdata_o` only after the read that removes it. When it is 1, the oldest word is already on `rdata_o` before it is read, and a read advances to the next word. `OUT_REG` models an extra registered stage on the RAM output. Each of the two switches adds one cycle to the time between a write into an empty FIFO and that word becoming readable. The full flag, the count and the response to a read are not affected by either switch.

Latency convention: a request is sampled at rising edge k. A latency of N means that the output first shows the effect just after edge k+N-1. A latency of 1 therefore means the output changes at the sampling edge itself.

Top module: `sc_fifo`

## Requirements
- R1: `full_o` is high exactly when the stored count equals `DEPTH`. It follows an accepted write or read with latency 1.
- R2: `usedw_o` rises by one for each accepted write and falls by one for each accepted read, with latency 1. It never exceeds `DEPTH`.
- R3: A write request while `full_o` is high is dropped, even when a read is accepted in the same cycle. The dropped word is never returned.
- R4: A read request while `empty_o` is high is dropped and leaves the read position and count unchanged. A later write is then read back first.
- R5: An accepted write and an accepted read in the same cycle leave `usedw_o` unchanged.
- R6: With `SHOW_AHEAD`=0, `empty_o` falls after a write into an empty FIFO with latency 1 when `OUT_REG`=0 and latency 2 when `OUT_REG`=1.
- R7: With `SHOW_AHEAD`=1, `empty_o` falls and the written word appears on `rdata_o` with latency 2 when `OUT_REG`=0 and latency 3 when `OUT_REG`=1.
- R8: An accepted read updates `rdata_o` and `empty_o` with latency 1 in every mode. With `SHOW_AHEAD`=0, `rdata_o` then shows the word just read. With `SHOW_AHEAD`=1, it shows the next word, or holds its value if none is readable.
- R9: Words leave the FIFO in the order they were accepted.
- R10: `clr_i` takes priority over both requests. It empties the FIFO with latency 1: `empty_o`=1, `full_o`=0 and `usedw_o`=0. Writes that were still in flight never surface.
- R11: After reset, `empty_o`=1, `full_o`=0, `usedw_o`=0 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear |
| wr_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read request |
| rdata_o | output | DATA_W | Read data / head word |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | No readable word |
| usedw_o | output | $clog2(DEPTH+1) | Stored word count |

## Verification
The bench builds four copies with `DEPTH`=8 and `DATA_W`=8, one for each pairing of `SHOW_AHEAD` and `OUT_REG`. The shallow depth brings the full boundary, write-while-full and pointer wrap within a few cycles. Running all four pairings exercises the empty-flag delays of 1, 2, 2 and 3 cycles side by side. Every cycle, a queue model that knows only the per-mode delay is compared with the flags, the count and the data.

// File: rtl/sc_fifo_pkg.sv
package sc_fifo_pkg;

  // cycles between an accepted write and the word becoming readable, beyond the write edge
  function automatic int unsigned flag_delay(input bit show_ahead, input bit out_reg);
    int unsigned d;
    d = 0;
    if (show_ahead) d++;
    if (out_reg) d++;
    return d;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/sc_fifo_ptrs.sv
module sc_fifo_ptrs #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_acc_i,
  input  logic          rd_acc_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [AW-1:0] rptr_nxt_o,
  output logic [CW-1:0] used_o,
  output logic          full_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] used_q, used_nxt;
  logic          full_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign rptr_nxt_o = rd_acc_i ? bump(rptr_q) : rptr_q;

  always_comb begin
    used_nxt = used_q;
    unique case ({wr_acc_i, rd_acc_i})
      2'b10:   used_nxt = used_q + 1'b1;
      2'b01:   used_nxt = used_q - 1'b1;
      default: used_nxt = used_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      used_q <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      used_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_acc_i) wptr_q <= bump(wptr_q);
      rptr_q <= rptr_nxt_o;
      used_q <= used_nxt;
      full_q <= (used_nxt == FULL_CNT);
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
  assign used_o = used_q;
  assign full_o = full_q;

  p_used_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= FULL_CNT)
    else $error("usedw beyond depth");

  p_rptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_acc_i && !clr_i) |=> $stable(rptr_q))
    else $error("read pointer moved without a read");

endmodule

// File: rtl/sc_fifo_avail.sv
module sc_fifo_avail #(
  parameter int unsigned DELAY = 0,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_acc_i,
  input  logic          rd_acc_i,
  output logic          empty_o,
  output logic          head_ld_o,
  output logic [CW-1:0] avail_o
);

  logic          wr_due;
  logic [CW-1:0] avail_q, avail_nxt;
  logic          empty_q;

  // delay line: a write counts as readable only after DELAY extra edges
  if (DELAY == 0) begin : g_direct
    assign wr_due = wr_acc_i;
  end else begin : g_pipe
    logic [DELAY-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '0;
      end else if (clr_i) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= wr_acc_i;
        for (int i = 1; i < int'(DELAY); i++) pipe_q[i] <= pipe_q[i-1];
      end
    end
    assign wr_due = pipe_q[DELAY-1];
  end

  always_comb begin
    avail_nxt = avail_q;
    unique case ({wr_due, rd_acc_i})
      2'b10:   avail_nxt = avail_q + 1'b1;
      2'b01:   avail_nxt = avail_q - 1'b1;
      default: avail_nxt = avail_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= '0;
      empty_q <= 1'b1;
    end else if (clr_i) begin
      avail_q <= '0;
      empty_q <= 1'b1;
    end else begin
      avail_q <= avail_nxt;
      empty_q <= (avail_nxt == '0);
    end
  end

  assign head_ld_o = !clr_i && (avail_nxt != '0);
  assign empty_o   = empty_q;
  assign avail_o   = avail_q;

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc_i |-> !empty_q)
    else $error("read accepted with nothing readable");

  p_read_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc_i && !wr_due && !clr_i && avail_q == CW'(1)) |=> empty_q)
    else $error("empty not raised after last readable word");

endmodule

// File: rtl/sc_fifo_mem.sv
module sc_fifo_mem #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned AW         = 4,
  parameter bit          SHOW_AHEAD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_acc_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic              head_ld_i,
  input  logic [AW-1:0]     head_addr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  if (SHOW_AHEAD) begin : g_ahead
    // head register always tracks the oldest readable word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_q <= '0;
      else if (head_ld_i) q_q <= mem_q[head_addr_i];
    end
    logic unused_ok;
    assign unused_ok = ^{rd_acc_i, raddr_i};
  end else begin : g_normal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q <= '0;
      else if (rd_acc_i) q_q <= mem_q[raddr_i];
    end
    logic unused_ok;
    assign unused_ok = ^{head_ld_i, head_addr_i};
  end

  assign rdata_o = q_q;

endmodule

// File: rtl/sc_fifo.sv
module sc_fifo
  import sc_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 16,
  parameter bit          SHOW_AHEAD = 1'b0,
  parameter bit          OUT_REG    = 1'b0,
  localparam int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW        = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     usedw_o
);

  localparam int unsigned DELAY = flag_delay(SHOW_AHEAD, OUT_REG);

  logic          wr_acc, rd_acc, head_ld;
  logic [AW-1:0] wptr, rptr, rptr_nxt;
  logic [CW-1:0] avail;

  // clear wins over both requests
  assign wr_acc = wr_i && !full_o  && !clr_i;
  assign rd_acc = rd_i && !empty_o && !clr_i;

  sc_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_acc_i  (wr_acc),
    .rd_acc_i  (rd_acc),
    .wptr_o    (wptr),
    .rptr_o    (rptr),
    .rptr_nxt_o(rptr_nxt),
    .used_o    (usedw_o),
    .full_o    (full_o)
  );

  sc_fifo_avail #(.DELAY(DELAY), .CW(CW)) u_avail (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .wr_acc_i (wr_acc),
    .rd_acc_i (rd_acc),
    .empty_o  (empty_o),
    .head_ld_o(head_ld),
    .avail_o  (avail)
  );

  sc_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .SHOW_AHEAD(SHOW_AHEAD)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_acc),
    .waddr_i    (wptr),
    .wdata_i    (wdata_i),
    .rd_acc_i   (rd_acc),
    .raddr_i    (rptr),
    .head_ld_i  (head_ld),
    .head_addr_i(rptr_nxt),
    .rdata_o    (rdata_o)
  );

  p_full_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (usedw_o == CW'(DEPTH)))
    else $error("full without full count");

  p_avail_le_used_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail <= usedw_o)
    else $error("readable words exceed stored words");

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !clr_i) |=> $stable(usedw_o))
    else $error("write while full changed count");

  p_rd_empty_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i && !clr_i) |=> $stable(usedw_o))
    else $error("read while empty changed count");

  p_rw_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !full_o && !empty_o && !clr_i) |=> $stable(usedw_o))
    else $error("simultaneous read and write changed count");

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !full_o && usedw_o == '0))
    else $error("clear did not empty the FIFO");

endmodule

// File: tb/sc_fifo_lane.sv
module sc_fifo_lane #(
  parameter bit SA    = 1'b0,
  parameter bit OREG  = 1'b0,
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output int   checks_o,
  output int   errors_o,
  output logic done_o
);

  localparam int DLY       = (SA ? 1 : 0) + (OREG ? 1 : 0);
  localparam int EMPTY_LAT = DLY + 1;   // from R6 / R7
  localparam int CW        = $clog2(DEPTH + 1);

  logic          clr, wr, rd;
  logic [7:0]    din, q;
  logic          full, empty;
  logic [CW-1:0] used;

  sc_fifo #(.DATA_W(8), .DEPTH(DEPTH), .SHOW_AHEAD(SA), .OUT_REG(OREG)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .wr_i   (wr),
    .wdata_i(din),
    .rd_i   (rd),
    .rdata_o(q),
    .full_o (full),
    .empty_o(empty),
    .usedw_o(used)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] mq[$];
  int         avail = 0;
  bit         pipe[3];
  logic [7:0] mq_out = 8'h00;

  assign checks_o = checks;
  assign errors_o = errors;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lane sa=%0d oreg=%0d act=%0h exp=%0h at %0t", req, SA, OREG, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit aw, ar, due;
    if (clr) begin
      mq.delete();
      avail = 0;
      foreach (pipe[i]) pipe[i] = 1'b0;
      return;
    end
    aw  = wr && (mq.size() < DEPTH);
    ar  = rd && (avail > 0);
    due = (DLY == 0) ? aw : pipe[(DLY == 0) ? 0 : DLY - 1];
    for (int i = 2; i > 0; i--) pipe[i] = pipe[i-1];
    pipe[0] = aw;
    if (ar) begin
      if (!SA) mq_out = mq[0];
      void'(mq.pop_front());
    end
    if (aw) mq.push_back(din);
    avail = avail + int'(due) - int'(ar);
    if (SA && avail > 0) mq_out = mq[0];
  endtask

  task automatic compare();
    check("R1", int'(full), int'(mq.size() == DEPTH));
    check("R2", int'(used), mq.size());
    check(SA ? "R7" : "R6", int'(empty), int'(avail == 0));
    check("R8", int'(q), int'(mq_out));
  endtask

  task automatic step(input bit w, input bit r, input bit c, input logic [7:0] d);
    wr = w; rd = r; clr = c; din = d;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    check("R11", int'(empty), 1);
    check("R11", int'(full), 0);
    check("R11", int'(used), 0);
    check("R11", int'(q), 0);
  endtask

  task automatic t_latency();
    int n;
    step(1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'hA5);
    n = 1;
    while (empty && n < 6) begin
      idle(1);
      n++;
    end
    check(SA ? "R7" : "R6", n, EMPTY_LAT);
    if (SA) check("R7", int'(q), 8'hA5);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R8", int'(q), 8'hA5);
    check("R8", int'(empty), 1);
  endtask

  task automatic t_fill();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b0, 8'(8'h10 + i));
    check("R1", int'(full), 1);
    check("R3", int'(used), DEPTH);
    idle(3);
    step(1'b1, 1'b1, 1'b0, 8'hEE);
    check("R3", int'(used), DEPTH - 1);
    check("R1", int'(full), 0);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R3", int'(used), 0);
  endtask

  task automatic t_drain();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h21);
    step(1'b1, 1'b0, 1'b0, 8'h22);
    idle(3);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R4", int'(used), 0);
    check("R4", int'(empty), 1);
    step(1'b1, 1'b0, 1'b0, 8'h23);
    idle(3);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R4", int'(q), 8'h23);
  endtask

  task automatic t_simul();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 8'(8'h40 + i));
    idle(3);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, 1'b0, 8'(8'h50 + i));
      check("R5", int'(used), 3);
    end
    idle(3);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_order();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 8'(8'h30 + i));
    idle(3);
    for (int i = 0; i < 5; i++) begin
      if (SA) check("R9", int'(q), 8'h30 + i);
      step(1'b0, 1'b1, 1'b0, 8'h00);
      if (!SA) check("R9", int'(q), 8'h30 + i);
    end
    // mixed traffic across pointer wrap, compared cycle by cycle
    for (int i = 0; i < 40; i++)
      step(bit'((i % 3) != 2), bit'((i % 2) == 0), 1'b0, 8'(8'h60 + i));
  endtask

  task automatic t_clear();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 8'(8'h70 + i));
    step(1'b1, 1'b1, 1'b1, 8'h77);
    check("R10", int'(empty), 1);
    check("R10", int'(used), 0);
    check("R10", int'(full), 0);
    idle(3);
    check("R10", int'(empty), 1);
  endtask

  initial begin
    done_o = 1'b0;
    clr = 1'b0; wr = 1'b0; rd = 1'b0; din = 8'h00;
    foreach (pipe[i]) pipe[i] = 1'b0;
    wait (rst_ni === 1'b1);
    @(negedge clk_i);
    t_reset();
    t_latency();
    t_fill();
    t_drain();
    t_simul();
    t_order();
    t_clear();
    done_o = 1'b1;
  end

endmodule

// File: tb/sc_fifo_tb.sv
module sc_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  int         lane_checks[4];
  int         lane_errors[4];
  logic [3:0] lane_done;

  always #4 clk = ~clk;   // 125 MHz

  for (genvar g = 0; g < 4; g++) begin : g_lane
    sc_fifo_lane #(.SA(bit'(g / 2)), .OREG(bit'(g % 2)), .DEPTH(8)) u_lane (
      .clk_i   (clk),
      .rst_ni  (rst_ni),
      .checks_o(lane_checks[g]),
      .errors_o(lane_errors[g]),
      .done_o  (lane_done[g])
    );
  end

  initial begin
    int total_checks;
    int total_errors;
    bit timed_out;
    timed_out = 1'b1;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(posedge clk);
      if (&lane_done) begin
        timed_out = 1'b0;
        break;
      end
    end
    @(negedge clk);
    total_checks = 0;
    total_errors = 0;
    for (int i = 0; i < 4; i++) begin
      total_checks += lane_checks[i];
      total_errors += lane_errors[i];
    end
    if (timed_out) begin
      total_checks++;
      total_errors++;
      $display("FAIL watchdog R1..all lanes act=%0b exp=1111", lane_done);
    end
    $display("CHECKS %0d ERRORS %0d", total_checks, total_errors);
    $finish;
  end

endmodule